// File: doc/BRIEF.md
# Power Domain Sequencer

This block sequences power transitions for a small set of on-chip power domains. For every domain it owns three groups of control lines: a power switch word, a bank of reset lines and a bank of isolation lines. The power word is shared by all domains, and so are the reset and isolation banks. Each domain selects its bits in each word through a mask that is fixed at build time.

A request names one domain and a direction. The block accepts it when idle and then performs the steps of that direction one at a time. A programmable delay separates consecutive steps. `busy_o` is high for the whole walk, and a single-cycle `done_o` marks its end. A step whose mask is empty for the chosen domain is left out and costs no time. The power step always runs.

Polarities: a set power bit switches the domain off. Reset and isolation lines are active-low, so a cleared bit holds the unit in reset or clamps its outputs.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset `pwr_o` equals `PWR_INIT` (default 0x1C), `rst_o` and `iso_o` are all zeros, and `busy_o` and `done_o` are low.
- R2: A power-up request runs its steps in this order: clear the domain's power bits, then set its reset bits, then set its isolation bits.
- R3: A power-down request runs its steps in this order: clear the domain's isolation bits, then clear its reset bits, then set its power bits.
- R4: Each step changes only the bits in that domain's mask for the register it touches. The other two registers, and all bits outside the mask, keep their values.
- R5: A reset or isolation step whose mask is zero for the domain is skipped and takes no cycles. The power step is never skipped. With the defaults, domain 2 has power mask 0x10 and no reset or isolation bits.
- R6: The first step is applied on the clock edge after the request is accepted. Each later step follows the one before it by `delay_i + 1` cycles. The `delay_i` value used is the one sampled when the request is accepted.
- R7: A request is accepted only while `busy_o` is low. `busy_o` goes high on the edge after acceptance and falls on the edge that applies the last step. Requests made while busy have no effect.
- R8: `done_o` is high for exactly one cycle, the cycle right after the last step is applied.
- R9: `dom_on_o[d]` is high exactly when none of domain d's power-mask bits is set in `pwr_o`. This holds from reset onward.
- R10: A request whose domain index is `NUM_DOM` or larger is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_dom_i | input | DOM_W | Index of the target domain |
| req_on_i | input | 1 | 1 = power up, 0 = power down |
| delay_i | input | DLY_W | Spacing between steps, sampled when a request is accepted |
| pwr_o | output | PWR_W | Power switch word; 1 = off |
| rst_o | output | RST_W | Reset lines, active low |
| iso_o | output | ISO_W | Isolation lines, active low |
| dom_on_o | output | NUM_DOM | Per-domain powered-up state |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench walks both directions with delays of zero, one, two and three cycles. It then checks every output word on every cycle. A reversed step order or a wrong polarity would show up as the wrong register changing first. A mask applied to the wrong word would disturb bits that belong to a neighbouring domain.

Domain 2 has no reset or isolation bits. A design that still waited for its absent steps would keep `busy_o` high too long and raise `done_o` late. Some extra requests arrive while the block is busy or name an invalid domain. A design that accepted any of them would change a register that should have stayed still. The bench also changes `delay_i` after acceptance, so a design that kept reading it would produce the wrong gaps between steps.

// File: rtl/pwr_dom_seq_pkg.sv
package pwr_dom_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STEP,
    ST_WAIT
  } seq_st_e;

  typedef enum logic [1:0] {
    STEP_PWR,
    STEP_RST,
    STEP_ISO,
    STEP_NONE
  } step_e;

  localparam logic [1:0] IDX_NONE = 2'd3;

  // up: power, reset, isolation; down: isolation, reset, power
  function automatic step_e step_of(input logic up, input logic [1:0] idx);
    step_e s;
    case (idx)
      2'd0:    s = up ? STEP_PWR : STEP_ISO;
      2'd1:    s = STEP_RST;
      2'd2:    s = up ? STEP_ISO : STEP_PWR;
      default: s = STEP_NONE;
    endcase
    return s;
  endfunction

  function automatic logic step_present(input logic up, input logic has_rst,
                                        input logic has_iso, input logic [1:0] idx);
    step_e s;
    s = step_of(up, idx);
    return (s == STEP_PWR) || (s == STEP_RST && has_rst) || (s == STEP_ISO && has_iso);
  endfunction

  // first present step at or after idx 'from'
  function automatic logic [1:0] next_present(input logic up, input logic has_rst,
                                              input logic has_iso, input logic [2:0] from);
    logic [1:0] r;
    r = IDX_NONE;
    for (int i = 2; i >= 0; i--) begin
      if (3'(i) >= from && step_present(up, has_rst, has_iso, 2'(i))) r = 2'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/pwr_dom_seq_ctrl.sv
module pwr_dom_seq_ctrl
  import pwr_dom_seq_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int DLY_W   = 8,
  localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [DOM_W-1:0]   req_dom_i,
  input  logic               req_on_i,
  input  logic [DLY_W-1:0]   delay_i,
  input  logic [NUM_DOM-1:0] has_rst_i,
  input  logic [NUM_DOM-1:0] has_iso_i,
  output logic               apply_o,
  output step_e              step_o,
  output logic [DOM_W-1:0]   dom_o,
  output logic               up_o,
  output logic               busy_o,
  output logic               done_o
);

  seq_st_e          st_q, st_d;
  logic [DOM_W-1:0] dom_q;
  logic             up_q;
  logic [DLY_W-1:0] dly_q, cnt_q;
  logic [1:0]       idx_q;
  logic             done_q;
  logic             dom_ok, accept;
  logic [1:0]       first_idx, nxt_idx;

  assign dom_ok    = int'(req_dom_i) < NUM_DOM;
  assign accept    = (st_q == ST_IDLE) && req_valid_i && dom_ok;
  assign first_idx = next_present(req_on_i, has_rst_i[req_dom_i], has_iso_i[req_dom_i], 3'd0);
  assign nxt_idx   = next_present(up_q, has_rst_i[dom_q], has_iso_i[dom_q], {1'b0, idx_q} + 3'd1);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_STEP;
      ST_STEP: begin
        if (nxt_idx == IDX_NONE)  st_d = ST_IDLE;
        else if (dly_q != '0)     st_d = ST_WAIT;
      end
      ST_WAIT: if (cnt_q == '0) st_d = ST_STEP;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dom_q  <= '0;
      up_q   <= 1'b0;
      dly_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_STEP) && (nxt_idx == IDX_NONE);
      if (accept) begin
        dom_q <= req_dom_i;
        up_q  <= req_on_i;
        dly_q <= delay_i;
        idx_q <= first_idx;
      end
      if (st_q == ST_STEP && nxt_idx != IDX_NONE) begin
        idx_q <= nxt_idx;
        if (dly_q != '0) cnt_q <= dly_q - 1'b1;
      end
      if (st_q == ST_WAIT && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign apply_o = (st_q == ST_STEP);
  assign step_o  = step_of(up_q, idx_q);
  assign dom_o   = dom_q;
  assign up_o    = up_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_BUSY_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);  // R7
  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(dom_q) && $stable(up_q));  // R7
  AST_BAD_DOM_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !dom_ok) |=> !busy_o);  // R10

endmodule

// File: rtl/pwr_dom_seq_regs.sv
module pwr_dom_seq_regs
  import pwr_dom_seq_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int PWR_W   = 8,
  parameter int RST_W   = 32,
  parameter int ISO_W   = 8,
  parameter logic [NUM_DOM-1:0][PWR_W-1:0] PWR_MASKS = '0,
  parameter logic [NUM_DOM-1:0][RST_W-1:0] RST_MASKS = '0,
  parameter logic [NUM_DOM-1:0][ISO_W-1:0] ISO_MASKS = '0,
  parameter logic [PWR_W-1:0] PWR_INIT = '1,
  localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               apply_i,
  input  step_e              step_i,
  input  logic [DOM_W-1:0]   dom_i,
  input  logic               up_i,
  output logic [NUM_DOM-1:0] has_rst_o,
  output logic [NUM_DOM-1:0] has_iso_o,
  output logic [PWR_W-1:0]   pwr_o,
  output logic [RST_W-1:0]   rst_o,
  output logic [ISO_W-1:0]   iso_o,
  output logic [NUM_DOM-1:0] dom_on_o
);

  logic [PWR_W-1:0] pwr_q, pm;
  logic [RST_W-1:0] rst_q, rm;
  logic [ISO_W-1:0] iso_q, im;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    assign has_rst_o[g] = |RST_MASKS[g];
    assign has_iso_o[g] = |ISO_MASKS[g];
    assign dom_on_o[g]  = ~|(pwr_q & PWR_MASKS[g]);
  end

  assign pm = PWR_MASKS[dom_i];
  assign rm = RST_MASKS[dom_i];
  assign im = ISO_MASKS[dom_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= PWR_INIT;
      rst_q <= '0;
      iso_q <= '0;
    end else if (apply_i) begin
      case (step_i)
        STEP_PWR: pwr_q <= up_i ? (pwr_q & ~pm) : (pwr_q | pm);
        STEP_RST: rst_q <= up_i ? (rst_q | rm) : (rst_q & ~rm);
        STEP_ISO: iso_q <= up_i ? (iso_q | im) : (iso_q & ~im);
        default: ;
      endcase
    end
  end

  assign pwr_o = pwr_q;
  assign rst_o = rst_q;
  assign iso_o = iso_q;

  AST_ONE_WORD_PER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!$stable(pwr_q), !$stable(rst_q), !$stable(iso_q)}) <= 1);  // R4
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(pwr_q) && $stable(rst_q) && $stable(iso_q));  // R7

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_dom_seq_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int PWR_W   = 8,
  parameter int RST_W   = 32,
  parameter int ISO_W   = 8,
  parameter int DLY_W   = 8,
  parameter logic [NUM_DOM-1:0][PWR_W-1:0] PWR_MASKS = {8'h10, 8'h04, 8'h08},
  parameter logic [NUM_DOM-1:0][RST_W-1:0] RST_MASKS = {32'h0, 32'h0004_0000, 32'h0001_0000},
  parameter logic [NUM_DOM-1:0][ISO_W-1:0] ISO_MASKS = {8'h00, 8'h02, 8'h01},
  parameter logic [PWR_W-1:0] PWR_INIT = 8'h1C,
  localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [DOM_W-1:0]   req_dom_i,
  input  logic               req_on_i,
  input  logic [DLY_W-1:0]   delay_i,
  output logic [PWR_W-1:0]   pwr_o,
  output logic [RST_W-1:0]   rst_o,
  output logic [ISO_W-1:0]   iso_o,
  output logic [NUM_DOM-1:0] dom_on_o,
  output logic               busy_o,
  output logic               done_o
);

  logic               apply;
  step_e              step;
  logic [DOM_W-1:0]   dom;
  logic               up;
  logic [NUM_DOM-1:0] has_rst, has_iso;

  pwr_dom_seq_ctrl #(
    .NUM_DOM(NUM_DOM),
    .DLY_W  (DLY_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_dom_i  (req_dom_i),
    .req_on_i   (req_on_i),
    .delay_i    (delay_i),
    .has_rst_i  (has_rst),
    .has_iso_i  (has_iso),
    .apply_o    (apply),
    .step_o     (step),
    .dom_o      (dom),
    .up_o       (up),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  pwr_dom_seq_regs #(
    .NUM_DOM  (NUM_DOM),
    .PWR_W    (PWR_W),
    .RST_W    (RST_W),
    .ISO_W    (ISO_W),
    .PWR_MASKS(PWR_MASKS),
    .RST_MASKS(RST_MASKS),
    .ISO_MASKS(ISO_MASKS),
    .PWR_INIT (PWR_INIT)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .apply_i  (apply),
    .step_i   (step),
    .dom_i    (dom),
    .up_i     (up),
    .has_rst_o(has_rst),
    .has_iso_o(has_iso),
    .pwr_o    (pwr_o),
    .rst_o    (rst_o),
    .iso_o    (iso_o),
    .dom_on_o (dom_on_o)
  );

  AST_DONE_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(apply));  // R8

endmodule

// File: tb/pwr_dom_seq_tb_top.sv
module pwr_dom_seq_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_dom_i = '0;
  logic        req_on_i = 1'b0;
  logic [7:0]  delay_i = '0;
  logic [7:0]  pwr_o;
  logic [31:0] rst_o;
  logic [7:0]  iso_o;
  logic [2:0]  dom_on_o;
  logic        busy_o, done_o;

  always #5 clk_i = ~clk_i;

  pwr_dom_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_dom_i(req_dom_i),
    .req_on_i(req_on_i), .delay_i(delay_i), .pwr_o(pwr_o), .rst_o(rst_o), .iso_o(iso_o),
    .dom_on_o(dom_on_o), .busy_o(busy_o), .done_o(done_o)
  );

  localparam logic [7:0]  PM [3] = '{8'h08, 8'h04, 8'h10};
  localparam logic [31:0] RM [3] = '{32'h0001_0000, 32'h0004_0000, 32'h0};
  localparam logic [7:0]  IM [3] = '{8'h01, 8'h02, 8'h00};

  typedef struct {
    logic [7:0]  pwr;
    logic [31:0] rst;
    logic [7:0]  iso;
    logic [2:0]  on;
    logic        busy;
    logic        done;
    string       tag;
  } exp_t;

  exp_t q[$];
  int errors = 0, checks = 0;
  bit finished = 0;

  logic [7:0]  m_pwr = 8'h1C;
  logic [31:0] m_rst = '0;
  logic [7:0]  m_iso = '0;
  logic        m_busy = 0, m_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: drive inputs for one cycle and push the outputs expected after the edge
  task automatic tick(input bit v, input int d, input bit on, input int dl, input string tag);
    exp_t e;
    @(negedge clk_i);
    req_valid_i = v;
    req_dom_i   = 2'(d);
    req_on_i    = on;
    delay_i     = 8'(dl);
    e.pwr = m_pwr; e.rst = m_rst; e.iso = m_iso;
    for (int g = 0; g < 3; g++) e.on[g] = ((m_pwr & PM[g]) == 8'h0);
    e.busy = m_busy; e.done = m_done; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(pwr_o == e.pwr, {e.tag, " pwr"}, 32'(pwr_o), 32'(e.pwr));
        chk(rst_o == e.rst, {e.tag, " rst"}, rst_o, e.rst);
        chk(iso_o == e.iso, {e.tag, " iso"}, 32'(iso_o), 32'(e.iso));
        chk(dom_on_o == e.on, {e.tag, " R9 dom_on"}, 32'(dom_on_o), 32'(e.on));
        chk(busy_o == e.busy, {e.tag, " R7 busy"}, 32'(busy_o), 32'(e.busy));
        chk(done_o == e.done, {e.tag, " R8 done"}, 32'(done_o), 32'(e.done));
      end
    end
  end

  task automatic run(input int d, input bit up, input int dl, input bit poke);
    int steps[$];
    string t;
    t = up ? "R2 R4 R5" : "R3 R4 R5";
    if (up) begin
      steps.push_back(0);
      if (RM[d] != 0) steps.push_back(1);
      if (IM[d] != 0) steps.push_back(2);
    end else begin
      if (IM[d] != 0) steps.push_back(2);
      if (RM[d] != 0) steps.push_back(1);
      steps.push_back(0);
    end
    m_busy = 1; m_done = 0;
    tick(1, d, up, dl, "R7 accept");
    foreach (steps[i]) begin
      if (i > 0)
        for (int k = 0; k < dl; k++)
          tick(poke && k == 0, (d + 1) % 3, !up, 0, "R6 R7 gap");
      case (steps[i])
        0: m_pwr = up ? (m_pwr & ~PM[d]) : (m_pwr | PM[d]);
        1: m_rst = up ? (m_rst | RM[d]) : (m_rst & ~RM[d]);
        default: m_iso = up ? (m_iso | IM[d]) : (m_iso & ~IM[d]);
      endcase
      if (i == steps.size() - 1) begin m_busy = 0; m_done = 1; end
      tick(0, d, up, 7, t);  // delay_i changed after acceptance: R6
    end
    m_done = 0;
    tick(0, 0, 0, 0, "R8 after");
  endtask

  initial begin
    #100000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick(0, 0, 0, 0, "R1 reset");
    tick(0, 0, 0, 0, "R1 reset");
    tick(1, 3, 1, 0, "R10 bad dom");
    tick(0, 0, 0, 0, "R10 bad dom");
    run(0, 1, 0, 0);
    run(1, 1, 3, 1);
    run(2, 1, 2, 1);   // R5 single step
    run(0, 0, 1, 1);
    run(2, 0, 0, 0);   // R5
    run(1, 0, 2, 1);
    tick(1, 3, 0, 0, "R10 bad dom");
    tick(0, 0, 0, 0, "R10 bad dom");
    repeat (3) @(negedge clk_i);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule